// File: doc/BRIEF.md
# UART Control and Interrupt Register Block

This block is the register front end of a serial port. Software reaches it over a 32-bit word bus. It has no clock divider and no shifters; the transmit and receive cores sit beside it. The block keeps the transmit and receive enable states, which software changes by writing one-shot strobe bits to a command word. It shows the live state of the transmit path and the receive path in a read-only status word. It also collects transmit and receive events into an interrupt flag word.

Flags are never changed by a read-modify-write of the flag word. A write of ones to a set alias raises the matching flags, and a write of ones to a clear alias drops them. Two of the flags are edge events held until software clears them: transmission finished and receive overflow. The other two flags mirror levels from the cores: buffer has room and data waiting. The enable word gates the flags onto two interrupt lines, one for the receive side and one for the transmit side.

Top module: `uart_ctl_regs`

## Requirements
- R1: After reset the enable word is zero, both held event flags are zero, both directions are disabled, and both interrupt lines are low.
- R2: A write to the command word (offset 0x0C) with bit 0 set enables receive, and with bit 1 set disables it. Bit 2 enables transmit and bit 3 disables it. Each strobe takes effect at the write's clock edge, and zero bits leave the state unchanged.
- R3: When the enable and disable strobes for one direction are written together, the direction ends up disabled.
- R4: The status word (offset 0x10) reads these bits. Bit 1 is the transmit enable state. Bit 5 is the transmitter-idle input. Bit 6 is the buffer-room input. Bit 7 is the receive-data-available input. All other bits read 0, and the command word reads 0.
- R5: In the flag word (offset 0x40), bit 0 (transmission finished) is set by a one-cycle event pulse and bit 4 (receive overflow) is set by a one-cycle event pulse. Each stays set until cleared.
- R6: Writing ones to the set alias (offset 0x44) sets the matching held flags. Writing ones to the clear alias (offset 0x48) clears them. Zero bits have no effect, and both aliases read 0.
- R7: An event pulse in the same cycle as a clear-alias write of that flag leaves the flag set.
- R8: Flag bit 1 follows the buffer-room input and flag bit 2 follows the receive-data-available input, each one cycle later. Set-alias and clear-alias writes do not change them.
- R9: The enable word (offset 0x4C) stores bits 0, 1, 2 and 4 on a write and reads all other bits as 0.
- R10: The receive interrupt is high exactly when flag bit 2 or flag bit 4 is set together with the same enable bit. The transmit interrupt is high exactly when flag bit 0 or flag bit 1 is set together with the same enable bit.
- R11: Reads of any other address return 0, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| ev_tx_done | input | 1 | Pulse: last frame fully shifted out |
| ev_rx_overflow | input | 1 | Pulse: receive data lost |
| tx_line_idle | input | 1 | Level: transmitter idle |
| tx_buf_room | input | 1 | Level: transmit buffer can accept data |
| rx_data_avail | input | 1 | Level: receive data waiting |
| tx_enabled | output | 1 | Transmit enable state |
| rx_enabled | output | 1 | Receive enable state |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The assertions check on every cycle that disable wins over enable and that a strobe moves the enable state one edge later. They also check that an event pulse always leaves its flag set, even against a clear. They check that the level flags track their inputs with one cycle of lag and that a zero enable word silences both lines. Only the bench's scenarios can show the read-back encodings: the status and flag bit positions, the alias and unmapped reads returning zero, and the masking of the enable word. The same holds for ordinary flag clearing and setting through the aliases.

// File: rtl/uart_ctl_pkg.sv
`timescale 1ns/1ps
package uart_ctl_pkg;
  localparam int WORD_W = 32;
  localparam int FLAG_W = 5;

  localparam logic [7:0] OFS_CMD    = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_FLAGS  = 8'h40;
  localparam logic [7:0] OFS_FSET   = 8'h44;
  localparam logic [7:0] OFS_FCLR   = 8'h48;
  localparam logic [7:0] OFS_ENA    = 8'h4C;

  localparam int FB_TXDONE = 0;
  localparam int FB_ROOM   = 1;
  localparam int FB_RXAV   = 2;
  localparam int FB_RXOVF  = 4;

  localparam logic [FLAG_W-1:0] EDGE_MASK = FLAG_W'((1 << FB_TXDONE) | (1 << FB_RXOVF));
  localparam logic [FLAG_W-1:0] LVL_MASK  = FLAG_W'((1 << FB_ROOM) | (1 << FB_RXAV));
  localparam logic [FLAG_W-1:0] ENA_MASK  = EDGE_MASK | LVL_MASK;
  localparam logic [FLAG_W-1:0] RX_MASK   = FLAG_W'((1 << FB_RXAV) | (1 << FB_RXOVF));
  localparam logic [FLAG_W-1:0] TX_MASK   = FLAG_W'((1 << FB_TXDONE) | (1 << FB_ROOM));

  function automatic logic held_next(logic cur, logic hw, logic sw_set, logic sw_clr);
    return hw | sw_set | (cur & ~sw_clr);
  endfunction

  function automatic logic en_next(logic cur, logic on, logic off);
    return (cur | on) & ~off;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(logic txen, logic idle, logic room, logic rxav);
    logic [WORD_W-1:0] w;
    w    = '0;
    w[1] = txen;
    w[5] = idle;
    w[6] = room;
    w[7] = rxav;
    return w;
  endfunction
endpackage

// File: rtl/uart_ctl_cmd.sv
`timescale 1ns/1ps
module uart_ctl_cmd #(
  parameter int DIRS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [2*DIRS-1:0] strobes,
  output logic [DIRS-1:0] en_q
);
  import uart_ctl_pkg::*;

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    wire on_pulse  = cmd_we & strobes[2*d];
    wire off_pulse = cmd_we & strobes[2*d+1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[d] <= 1'b0;
      else        en_q[d] <= en_next(en_q[d], on_pulse, off_pulse);
    end
  end
endmodule

// File: rtl/uart_ctl_flags.sv
`timescale 1ns/1ps
module uart_ctl_flags
  import uart_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fset_we,
  input  logic              fclr_we,
  input  logic              ena_we,
  input  logic [FLAG_W-1:0] wbits,
  input  logic [FLAG_W-1:0] hw_pulse,
  input  logic [FLAG_W-1:0] hw_level,
  output logic [FLAG_W-1:0] flag_q,
  output logic [FLAG_W-1:0] ena_q,
  output logic              irq_rx,
  output logic              irq_tx
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (EDGE_MASK[b]) begin : g_held
      wire sw_set = fset_we & wbits[b];
      wire sw_clr = fclr_we & wbits[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[b] <= 1'b0;
        else        flag_q[b] <= held_next(flag_q[b], hw_pulse[b], sw_set, sw_clr);
      end
    end else if (LVL_MASK[b]) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[b] <= 1'b0;
        else        flag_q[b] <= hw_level[b];
      end
    end else begin : g_none
      assign flag_q[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (ena_we) ena_q <= wbits & ENA_MASK;
  end

  wire [FLAG_W-1:0] active = flag_q & ena_q;
  assign irq_rx = |(active & RX_MASK);
  assign irq_tx = |(active & TX_MASK);
endmodule

// File: rtl/uart_ctl_regs.sv
`timescale 1ns/1ps
module uart_ctl_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_tx_done,
  input  logic              ev_rx_overflow,
  input  logic              tx_line_idle,
  input  logic              tx_buf_room,
  input  logic              rx_data_avail,
  output logic              tx_enabled,
  output logic              rx_enabled,
  output logic              irq_rx,
  output logic              irq_tx
);
  import uart_ctl_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(OFS_FLAGS);
  localparam logic [ADDR_W-1:0] A_FSET   = ADDR_W'(OFS_FSET);
  localparam logic [ADDR_W-1:0] A_FCLR   = ADDR_W'(OFS_FCLR);
  localparam logic [ADDR_W-1:0] A_ENA    = ADDR_W'(OFS_ENA);

  // decoded write strobes, named for the checker
  wire wr_go   = bus_sel & bus_wr;
  wire cmd_we  = wr_go & (bus_addr == A_CMD);
  wire fset_we = wr_go & (bus_addr == A_FSET);
  wire fclr_we = wr_go & (bus_addr == A_FCLR);
  wire ena_we  = wr_go & (bus_addr == A_ENA);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[31:FLAG_W];

  logic [1:0] en_q; // [0] receive, [1] transmit
  uart_ctl_cmd #(.DIRS(2)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (cmd_we),
    .strobes (bus_wdata[3:0]),
    .en_q    (en_q)
  );
  assign rx_enabled = en_q[0];
  assign tx_enabled = en_q[1];

  logic [FLAG_W-1:0] hw_pulse, hw_level, if_flags, ien_flags;
  always_comb begin
    hw_pulse            = '0;
    hw_pulse[FB_TXDONE] = ev_tx_done;
    hw_pulse[FB_RXOVF]  = ev_rx_overflow;
    hw_level            = '0;
    hw_level[FB_ROOM]   = tx_buf_room;
    hw_level[FB_RXAV]   = rx_data_avail;
  end

  uart_ctl_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .fset_we  (fset_we),
    .fclr_we  (fclr_we),
    .ena_we   (ena_we),
    .wbits    (bus_wdata[FLAG_W-1:0]),
    .hw_pulse (hw_pulse),
    .hw_level (hw_level),
    .flag_q   (if_flags),
    .ena_q    (ien_flags),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        A_STATUS: bus_rdata = pack_status(tx_enabled, tx_line_idle, tx_buf_room, rx_data_avail);
        A_FLAGS:  bus_rdata = 32'(if_flags);
        A_ENA:    bus_rdata = 32'(ien_flags);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_ctl_regs_chk.sv
`timescale 1ns/1ps
module uart_ctl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic              fclr_we,
  input logic [31:0]       bus_wdata,
  input logic              ev_tx_done,
  input logic              ev_rx_overflow,
  input logic              tx_buf_room,
  input logic              rx_data_avail,
  input logic              tx_enabled,
  input logic              rx_enabled,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic [4:0]        if_flags,
  input logic [4:0]        ien_flags
);
  // R3: disable strobe beats enable strobe
  p_tx_dis_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && bus_wdata[3]) |=> !tx_enabled);
  p_rx_dis_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && bus_wdata[1]) |=> !rx_enabled);
  // R2: a lone enable strobe turns the direction on
  p_tx_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && bus_wdata[2] && !bus_wdata[3]) |=> tx_enabled);
  p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(rx_enabled));
  // R5, R7: event pulse always leaves its flag set
  p_txdone_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> if_flags[0]);
  p_rxovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overflow |=> if_flags[4]);
  // R5: held flag stays set without a clear of that bit
  p_txdone_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (if_flags[0] && !(fclr_we && bus_wdata[0])) |=> if_flags[0]);
  // R8: level flags lag their inputs by one cycle
  p_room_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (if_flags[1] == $past(tx_buf_room)));
  p_rxav_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (if_flags[2] == $past(rx_data_avail)));
  // R10: no enabled source means both lines stay low
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_flags == 5'b0) |-> (!irq_rx && !irq_tx));
endmodule

bind uart_ctl_regs uart_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_we         (cmd_we),
  .fclr_we        (fclr_we),
  .bus_wdata      (bus_wdata),
  .ev_tx_done     (ev_tx_done),
  .ev_rx_overflow (ev_rx_overflow),
  .tx_buf_room    (tx_buf_room),
  .rx_data_avail  (rx_data_avail),
  .tx_enabled     (tx_enabled),
  .rx_enabled     (rx_enabled),
  .irq_rx         (irq_rx),
  .irq_tx         (irq_tx),
  .if_flags       (if_flags),
  .ien_flags      (ien_flags)
);

// File: tb/uart_ctl_regs_test.sv
`timescale 1ns/1ps
module uart_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ev_tx_done = 1'b0, ev_rx_overflow = 1'b0;
  logic tx_line_idle = 1'b0, tx_buf_room = 1'b0, rx_data_avail = 1'b0;
  logic tx_enabled, rx_enabled, irq_rx, irq_tx;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_done(ev_tx_done), .ev_rx_overflow(ev_rx_overflow),
    .tx_line_idle(tx_line_idle), .tx_buf_room(tx_buf_room),
    .rx_data_avail(rx_data_avail), .tx_enabled(tx_enabled),
    .rx_enabled(rx_enabled), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // behavioural reference state
  bit m_tx, m_rx, m_done, m_ovf, m_room, m_av;
  bit [31:0] m_ien;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_done = 0; m_ovf = 0; m_room = 0; m_av = 0; m_ien = 0;
    end else begin
      bit w;
      w = bus_sel && bus_wr;
      if (w && bus_addr == 8'h0C) begin
        if (bus_wdata[1]) m_rx = 0; else if (bus_wdata[0]) m_rx = 1;
        if (bus_wdata[3]) m_tx = 0; else if (bus_wdata[2]) m_tx = 1;
      end
      if (ev_tx_done) m_done = 1;
      else if (w && bus_addr == 8'h44 && bus_wdata[0]) m_done = 1;
      else if (w && bus_addr == 8'h48 && bus_wdata[0]) m_done = 0;
      if (ev_rx_overflow) m_ovf = 1;
      else if (w && bus_addr == 8'h44 && bus_wdata[4]) m_ovf = 1;
      else if (w && bus_addr == 8'h48 && bus_wdata[4]) m_ovf = 0;
      m_room = tx_buf_room;
      m_av   = rx_data_avail;
      if (w && bus_addr == 8'h4C) m_ien = bus_wdata & 32'h17;
    end
  end

  function automatic [31:0] expect_read(input [7:0] a);
    case (a)
      8'h10: return (32'(m_tx) << 1) | (32'(tx_line_idle) << 5) |
                    (32'(tx_buf_room) << 6) | (32'(rx_data_avail) << 7);
      8'h40: return 32'(m_done) | (32'(m_room) << 1) | (32'(m_av) << 2) | (32'(m_ovf) << 4);
      8'h4C: return m_ien;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input [31:0] act, input [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of state-driven outputs (R2, R10)
  always @(negedge clk) if (rst_n && !finished) begin
    check("R2 rx_enabled", 32'(rx_enabled), 32'(m_rx));
    check("R2 tx_enabled", 32'(tx_enabled), 32'(m_tx));
    check("R10 irq_rx", 32'(irq_rx), 32'((m_av & m_ien[2]) | (m_ovf & m_ien[4])));
    check("R10 irq_tx", 32'(irq_tx), 32'((m_done & m_ien[0]) | (m_room & m_ien[1])));
  end

  task automatic wr(input [7:0] a, input [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input [7:0] a, input string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2;
    check(req, bus_rdata, expect_read(a));
    bus_sel = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq_rx", 32'(irq_rx), 0);
    check("R1 irq_tx", 32'(irq_tx), 0);
    rd(8'h4C, "R1 enable word");
    rd(8'h40, "R1 flags");
    rd(8'h10, "R1 status");

    // R2, R3, R4: command strobes
    wr(8'h0C, 32'h4); rd(8'h10, "R2 tx on");
    wr(8'h0C, 32'h1); rd(8'h10, "R2 rx on");
    rd(8'h0C, "R4 command reads zero");
    wr(8'h0C, 32'h0); rd(8'h10, "R2 zero write");
    wr(8'h0C, 32'h8); rd(8'h10, "R2 tx off");
    wr(8'h0C, 32'hF); rd(8'h10, "R3 both strobes");
    check("R3 rx off", 32'(rx_enabled), 0);
    wr(8'h0C, 32'h5);
    wr(8'h0C, 32'h3); check("R3 rx dis wins", 32'(rx_enabled), 0);

    // R4: status inputs
    tx_line_idle = 1; rd(8'h10, "R4 idle");
    tx_buf_room = 1; rd(8'h10, "R4 room");
    rx_data_avail = 1; rd(8'h10, "R4 rxav");
    tx_line_idle = 0; tx_buf_room = 0; rx_data_avail = 0;
    @(negedge clk);

    // R5: event pulses held
    ev_tx_done = 1; @(negedge clk); ev_tx_done = 0;
    rd(8'h40, "R5 done set");
    repeat (3) @(negedge clk); rd(8'h40, "R5 done held");
    ev_rx_overflow = 1; @(negedge clk); ev_rx_overflow = 0;
    rd(8'h40, "R5 ovf set");
    // R6: aliases
    wr(8'h48, 32'h1); rd(8'h40, "R6 clear done");
    wr(8'h48, 32'h0); rd(8'h40, "R6 zero clear");
    wr(8'h48, 32'h10); rd(8'h40, "R6 clear ovf");
    wr(8'h44, 32'h11); rd(8'h40, "R6 set both");
    rd(8'h44, "R6 set alias reads zero");
    rd(8'h48, "R6 clear alias reads zero");
    // R7: hardware set against clear
    ev_tx_done = 1; ev_rx_overflow = 1; wr(8'h48, 32'h11);
    ev_tx_done = 0; ev_rx_overflow = 0;
    rd(8'h40, "R7 set beats clear");
    wr(8'h48, 32'h11); rd(8'h40, "R7 cleared after");

    // R8: level flags
    tx_buf_room = 1; @(negedge clk); rd(8'h40, "R8 room follows");
    wr(8'h48, 32'h2); rd(8'h40, "R8 clear ignored");
    rx_data_avail = 1; tx_buf_room = 0;
    @(negedge clk); rd(8'h40, "R8 rxav follows");
    wr(8'h48, 32'h6); rd(8'h40, "R8 clear ignored rxav");
    rx_data_avail = 0; wr(8'h44, 32'h6); rd(8'h40, "R8 set ignored");

    // R9: enable word mask
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, "R9 mask");
    // R10: gating with several patterns
    tx_buf_room = 1; @(negedge clk);
    wr(8'h4C, 32'h02); check("R10 tx from room", 32'(irq_tx), 1);
    wr(8'h4C, 32'h14); check("R10 rx off", 32'(irq_rx), 0);
    ev_rx_overflow = 1; @(negedge clk); ev_rx_overflow = 0;
    check("R10 rx from ovf", 32'(irq_rx), 1);
    wr(8'h48, 32'h10); check("R10 rx cleared", 32'(irq_rx), 0);
    rx_data_avail = 1; @(negedge clk);
    check("R10 rx from rxav", 32'(irq_rx), 1);
    check("R10 tx masked", 32'(irq_tx), 0);
    rx_data_avail = 0; tx_buf_room = 0; @(negedge clk);

    // R11: unmapped
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h4D, 32'hFFFF_FFFF);
    rd(8'h4C, "R11 enable untouched");
    rd(8'h40, "R11 flags untouched");
    rd(8'h20, "R11 unmapped read");
    check("R11 tx state", 32'(tx_enabled), 32'(m_tx));

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule